// File: doc/BRIEF.md
# SD Host Block Count Engine

This block keeps track of how many data blocks remain in a multi-block transfer of an SD host controller. Software loads two count registers while the bus is idle: a short one of 16 bits and a long one of 32 bits. The block decides at run time which of the two is in use. The long register is chosen only when version-4 mode is on and the short register holds zero. In every other case the short register is used.

While a transfer runs with counting enabled, each block-done pulse takes one from the active count. A stop request is raised in the cycle where the last block completes. It is also raised at once when a transfer starts with a count of zero. The register choice and the counting enable are captured when the transfer starts and held until it ends. Register writes that arrive during a transfer are dropped. Reads return the live value of each register.

Top module: `sd_blkcnt_engine`

## Requirements
- R1: After reset both count registers read zero, and `remaining`, `last_blk` and `stop_req` are all zero.
- R2: When `xfer_active` is low, a write to address 0 loads `reg_wdata[15:0]` into the short register, and a write to address 1 loads all 32 bits into the long register. `reg_rdata` returns the short register zero-extended at address 0, the long register at address 1, and zero at any other address.
- R3: The long register is selected when `v4_en` is 1 and the short register is zero. Otherwise the short register is selected, zero-extended. `remaining` shows the selected register.
- R4: Counting is on only when `cnt_en` and `multi_blk` are both 1 in the first cycle of a transfer. Otherwise a block-done pulse changes no count, and `stop_req` and `last_blk` stay low.
- R5: With counting on, each cycle that has `blk_done` high during a transfer lowers the selected count by exactly one, provided that count is not zero.
- R6: `stop_req` is high in the same cycle as the `blk_done` pulse that meets a count of 1. A count of zero never wraps.
- R7: A transfer that starts with counting on and a selected count of zero raises `stop_req` in its first cycle.
- R8: Register writes made while `xfer_active` is high leave both registers unchanged.
- R9: The register selection and the counting enable are captured in the first cycle of `xfer_active`. Changes to `v4_en`, `cnt_en` or `multi_blk` during the transfer have no effect.
- R10: `last_blk` is high exactly when counting is on during a transfer and `remaining` equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 short, 1 long) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| v4_en | input | 1 | Version-4 mode enable |
| cnt_en | input | 1 | Block counting enable |
| multi_blk | input | 1 | Multi-block transfer select |
| xfer_active | input | 1 | High for the whole transfer |
| blk_done | input | 1 | One-cycle pulse per completed block |
| remaining | output | 32 | Selected remaining block count |
| last_blk | output | 1 | Remaining count is 1 while counting |
| stop_req | output | 1 | Transfer should end |

## Verification
Random transfers draw short counts that are either zero or small, so both register choices occur often. They also draw every combination of version-4 mode, counting enable and multi-block select. Because of this, a wrong selection shows up in `remaining`, and a wrong enable shows up in whether the count moves at all. Block-done pulses are sparse in some runs and dense in others, and they go on past a count of zero, which separates a correct stop from an early one, a late one or a wrap. Mid-transfer register writes and toggles of version-4 mode test whether the latching at transfer start really holds.

// File: rtl/sd_blkcnt_engine.sv
module sd_blkcnt_engine #(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LONG_W-1:0] reg_wdata,
  output logic [LONG_W-1:0] reg_rdata,
  input  logic              v4_en,
  input  logic              cnt_en,
  input  logic              multi_blk,
  input  logic              xfer_active,
  input  logic              blk_done,
  output logic [LONG_W-1:0] remaining,
  output logic              last_blk,
  output logic              stop_req
);
  localparam int PAD_W = LONG_W - SHORT_W;
  localparam logic [ADDR_W-1:0] ADDR_SHORT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_LONG  = ADDR_W'(1);

  logic [SHORT_W-1:0] short_q;
  logic [LONG_W-1:0]  long_q;
  logic act_q, sel_q, on_q;

  wire start   = xfer_active & ~act_q;
  wire sel_now = v4_en & (short_q == '0);
  wire on_now  = cnt_en & multi_blk;
  wire sel_eff = (xfer_active & ~start) ? sel_q : sel_now;
  wire on_eff  = xfer_active & (start ? on_now : on_q);

  assign remaining = sel_eff ? long_q : {{PAD_W{1'b0}}, short_q};

  wire rem_one  = (remaining == LONG_W'(1));
  wire rem_zero = (remaining == '0);
  wire dec      = on_eff & blk_done & ~rem_zero;

  assign last_blk = on_eff & rem_one;
  assign stop_req = on_eff & ((blk_done & rem_one) | (start & rem_zero));

  always_comb begin
    case (reg_addr)
      ADDR_SHORT: reg_rdata = {{PAD_W{1'b0}}, short_q};
      ADDR_LONG:  reg_rdata = long_q;
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_q <= '0;
      long_q  <= '0;
      act_q   <= 1'b0;
      sel_q   <= 1'b0;
      on_q    <= 1'b0;
    end else begin
      act_q <= xfer_active;
      if (start) begin
        sel_q <= sel_now;
        on_q  <= on_now;
      end
      if (!xfer_active && reg_wr) begin
        if (reg_addr == ADDR_SHORT) short_q <= reg_wdata[SHORT_W-1:0];
        if (reg_addr == ADDR_LONG)  long_q  <= reg_wdata;
      end else if (dec) begin
        if (sel_eff) long_q  <= long_q - LONG_W'(1);
        else         short_q <= short_q - SHORT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sd_blkcnt_engine_chk.sv
module sd_blkcnt_engine_chk #(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               xfer_active,
  input logic               blk_done,
  input logic [LONG_W-1:0]  remaining,
  input logic               last_blk,
  input logic               stop_req,
  input logic [SHORT_W-1:0] short_q,
  input logic [LONG_W-1:0]  long_q
);
  a_r8_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && reg_wr && !blk_done) |=> ($stable(short_q) && $stable(long_q)));

  a_r9_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && $past(xfer_active) && !$past(blk_done)) |-> $stable(remaining));

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && blk_done && last_blk) |=> (!xfer_active || remaining == '0));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && blk_done && remaining == '0) |=> (!xfer_active || remaining == '0));

  a_r6_stop_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> xfer_active);

  a_r10_last_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    last_blk |-> (xfer_active && remaining == LONG_W'(1)));
endmodule

bind sd_blkcnt_engine sd_blkcnt_engine_chk #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .xfer_active(xfer_active),
  .blk_done(blk_done), .remaining(remaining), .last_blk(last_blk),
  .stop_req(stop_req), .short_q(short_q), .long_q(long_q)
);

// File: tb/sd_blkcnt_engine_bench.sv
module sd_blkcnt_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic v4_en = 1'b0, cnt_en = 1'b0, multi_blk = 1'b0;
  logic xfer_active = 1'b0, blk_done = 1'b0;
  logic [31:0] remaining;
  logic last_blk, stop_req;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m16 = '0;
  logic [31:0] m32 = '0;
  logic m_act = 1'b0, m_sel = 1'b0, m_on = 1'b0;

  always #4 clk = ~clk;

  sd_blkcnt_engine u_sd_blkcnt_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .v4_en(v4_en),
    .cnt_en(cnt_en), .multi_blk(multi_blk), .xfer_active(xfer_active),
    .blk_done(blk_done), .remaining(remaining), .last_blk(last_blk),
    .stop_req(stop_req)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    return (a == 2'd0) ? {16'h0, m16} : (a == 2'd1) ? m32 : 32'h0;
  endfunction

  // Checks outputs against the requirement model, then advances one clock.
  task automatic step(input string tag);
    logic start, seln, sel_e, on_e, rem1, remz;
    logic [31:0] rem;
    #1;
    start = xfer_active && !m_act;
    seln  = v4_en && (m16 == 16'h0);
    sel_e = (xfer_active && !start) ? m_sel : seln;
    on_e  = xfer_active && (start ? (cnt_en && multi_blk) : m_on);
    rem   = sel_e ? m32 : {16'h0, m16};
    rem1  = (rem == 32'd1);
    remz  = (rem == 32'd0);
    chk(tag, "remaining", remaining, rem);
    chk(tag, "last_blk", {31'h0, last_blk}, {31'h0, on_e && rem1});
    chk(tag, "stop_req", {31'h0, stop_req}, {31'h0, on_e && ((blk_done && rem1) || (start && remz))});
    chk(tag, "reg_rdata", reg_rdata, exp_rdata(reg_addr));
    @(posedge clk);
    if (!xfer_active && reg_wr) begin
      if (reg_addr == 2'd0) m16 = reg_wdata[15:0];
      if (reg_addr == 2'd1) m32 = reg_wdata;
    end else if (on_e && blk_done && !remz) begin
      if (sel_e) m32 = m32 - 1;
      else       m16 = m16 - 1;
    end
    if (start) begin m_sel = seln; m_on = cnt_en && multi_blk; end
    m_act = xfer_active;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(tag);
    reg_wr = 1'b0;
  endtask

  task automatic done_pulse(input string tag);
    blk_done = 1'b1; step(tag); blk_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_addr = 2'd1; step("R1");
    reg_addr = 2'd0; step("R1");
    chk("R1", "remaining", remaining, 32'h0);
    // R2 register writes and reads
    wr(2'd0, 32'hABCD_0003, "R2");
    chk("R2", "short readback", reg_rdata, 32'h0000_0003);
    wr(2'd1, 32'h0001_0005, "R2");
    reg_addr = 2'd1; step("R2");
    chk("R2", "long readback", reg_rdata, 32'h0001_0005);
    reg_addr = 2'd2; step("R2");
    chk("R2", "unmapped read", reg_rdata, 32'h0);
    // R3 selection
    v4_en = 1'b1; step("R3");
    chk("R3", "short nonzero wins", remaining, 32'd3);
    wr(2'd0, 32'h0, "R3");
    chk("R3", "long selected", remaining, 32'h0001_0005);
    v4_en = 1'b0; step("R3");
    chk("R3", "v4 off picks short", remaining, 32'h0);
    // R7 zero count at start
    cnt_en = 1'b1; multi_blk = 1'b1; xfer_active = 1'b1;
    #1 chk("R7", "stop at zero start", {31'h0, stop_req}, 32'd1);
    step("R7");
    xfer_active = 1'b0; step("R7");
    // R9 latched selection with long count, v4 toggled mid transfer
    v4_en = 1'b1; wr(2'd1, 32'd2, "R9");
    xfer_active = 1'b1; step("R9");
    v4_en = 1'b0; step("R9");
    chk("R9", "long kept after v4 drop", remaining, 32'd2);
    // R10 last block, R5 decrement, R6 stop and no wrap
    done_pulse("R5");
    chk("R5", "decremented", remaining, 32'd1);
    chk("R10", "last_blk", {31'h0, last_blk}, 32'd1);
    blk_done = 1'b1; #1;
    chk("R6", "stop on final done", {31'h0, stop_req}, 32'd1);
    step("R6"); blk_done = 1'b0;
    done_pulse("R6");
    chk("R6", "no wrap", remaining, 32'd0);
    // R8 writes dropped in transfer
    wr(2'd1, 32'h55, "R8"); wr(2'd0, 32'h7, "R8");
    xfer_active = 1'b0; reg_addr = 2'd1; step("R8");
    chk("R8", "long unchanged", reg_rdata, 32'd0);
    // R4 counting disabled
    wr(2'd0, 32'd1, "R4");
    cnt_en = 1'b0; xfer_active = 1'b1; step("R4");
    blk_done = 1'b1; #1;
    chk("R4", "no stop when disabled", {31'h0, stop_req}, 32'd0);
    step("R4"); blk_done = 1'b0;
    chk("R4", "count held", remaining, 32'd1);
    xfer_active = 1'b0; step("R4");
    // Random transfers
    void'($urandom(32'h5D0C_2025));
    for (int t = 0; t < 400; t++) begin
      v4_en = $urandom_range(0, 1);
      wr(2'd0, ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 4)) : 32'h0, "R2");
      wr(2'd1, 32'($urandom_range(0, 6)), "R3");
      cnt_en = ($urandom_range(0, 3) != 0);
      multi_blk = ($urandom_range(0, 3) != 0);
      xfer_active = 1'b1;
      for (int c = 0, dens = $urandom_range(1, 3); c < 14; c++) begin
        blk_done = ($urandom_range(0, dens) != 0);
        v4_en = ($urandom_range(0, 4) == 0) ? ~v4_en : v4_en;
        cnt_en = ($urandom_range(0, 5) == 0) ? ~cnt_en : cnt_en;
        reg_wr = ($urandom_range(0, 4) == 0);
        reg_addr = 2'($urandom_range(0, 3));
        reg_wdata = $urandom;
        step("R6");
        reg_wr = 1'b0;
      end
      blk_done = 1'b0; xfer_active = 1'b0;
      reg_addr = 2'($urandom_range(0, 3));
      step("R5");
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule